// File: doc/BRIEF.md
# Replica-Checked Product Selector

This block sits behind a pair of multipliers that compute the same product. The main multiplier has 12-bit operands and may give wrong answers when its supply is pushed below the level its timing needs. The replica multiplier works on 6-bit slices of the same operands, so it has a short path that keeps giving correct, though coarse, results. Each sample, the block takes both products and moves the replica result up to the bit weights of the main result. It then takes the magnitude of their difference and compares it with a threshold.

If the difference is within the threshold, the main product is passed on. If it is beyond the threshold, the main product is treated as corrupted and the aligned replica product is passed on instead. A flag marks each substituted sample, and a saturating counter keeps a tally of them. The threshold is meant to be set to the worst-case gap between an exact product and the replica's estimate. It is written through its own write-enable port.

Top module: `ant_err_selector`

## Requirements
- R1: A sample presented with `in_valid` high at a rising clock edge appears on `out_prod` with `out_valid` high exactly one cycle later.
- R2: The replica product is aligned before use by shifting it left by 12 bits (product width 24 minus replica product width 12), with zeros in bits 11:0.
- R3: The difference is taken as a magnitude, so equal gaps give the same decision whether the main product is above or below the aligned replica product.
- R4: When the magnitude is less than or equal to the threshold, `out_prod` carries the main product and `out_fix` is 0. Equality counts as a match.
- R5: When the magnitude is strictly greater than the threshold, `out_prod` carries the aligned replica product and `out_fix` is 1. The flag is raised in the same cycle as the `out_valid` of that sample.
- R6: `fix_count` increases by one for each valid sample that is replaced, and for no other sample.
- R7: `fix_count` is 16 bits wide and stops at 65535 (0xFFFF). Further replacements leave it there.
- R8: A write with `thr_we` high loads `thr_wdata` into the threshold at the clock edge. Samples taken from the next edge on use the new value. Reset does not clear the threshold.
- R9: Synchronous reset (`rst` high) clears `out_valid`, `out_prod`, `out_fix` and `fix_count` to zero.
- R10: A cycle with `in_valid` low gives `out_valid` 0 and `out_fix` 0 one cycle later. It leaves `fix_count` and `out_prod` unchanged, whatever the product inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Product inputs carry a sample this cycle |
| main_prod | input | 24 | Product from the full-precision multiplier |
| rep_prod | input | 12 | Product from the reduced-precision replica |
| thr_we | input | 1 | Load enable for the threshold |
| thr_wdata | input | 24 | New threshold value |
| out_valid | output | 1 | Output sample valid |
| out_prod | output | 24 | Selected product |
| out_fix | output | 1 | Replica product was selected for this sample |
| fix_count | output | 16 | Saturating count of replaced samples |

## Verification
The bench probes the comparison at a difference equal to the threshold and at one more than it. It does this with the main product both above and below the replica, and with a zero and a full-scale threshold. A design with a non-strict comparator, or one that dropped the sign handling in the magnitude, would flag the wrong samples there. It also checks that a threshold loaded before a reset still steers decisions after the reset. A design that reset the threshold would start flagging every nonzero gap. Idle cycles carry mismatching products to catch a design that counts or flags samples that are not valid. A long run of replacements catches a counter that wraps to zero instead of holding.

// File: rtl/ant_sel_pkg.sv
package ant_sel_pkg;

   typedef enum logic {
      PICK_MAIN    = 1'b0,
      PICK_REPLICA = 1'b1
   } pick_e;

   function automatic int prod_width(input int op_w);
      return 2 * op_w;
   endfunction

endpackage

// File: rtl/ant_align.sv
module ant_align #(
   parameter int DST_W = 24,
   parameter int SRC_W = 12
) (
   input  logic [SRC_W-1:0] src,
   output logic [DST_W-1:0] dst
);
   localparam int SHIFT = DST_W - SRC_W;

   generate
      if (SHIFT < 0) begin : g_bad_width
         $error("ant_align: source wider than destination");
      end else if (SHIFT == 0) begin : g_direct
         assign dst = src;
      end else begin : g_shifted
         assign dst = {src, {SHIFT{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/ant_absdiff.sv
module ant_absdiff #(
   parameter int W = 24
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mag
);
   logic [W:0]   raw;
   logic         neg;
   logic [W-1:0] low;

   always_comb begin
      raw = {1'b0, a} - {1'b0, b};
      neg = raw[W];
      low = raw[W-1:0];
      mag = neg ? (~low + {{(W-1){1'b0}}, 1'b1}) : low;
   end

   // R3: the magnitude plus the smaller operand rebuilds the larger one
   always_comb begin
      a_r3_mag_sum : assert ((({1'b0, mag} + {1'b0, ((a < b) ? a : b)}) ==
                              {1'b0, ((a < b) ? b : a)}))
         else $error("magnitude inconsistent with operands");
   end

endmodule

// File: rtl/ant_sat_counter.sv
module ant_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic at_top;

   generate
      if (W < 1) begin : g_bad_width
         $error("ant_sat_counter: width must be positive");
      end
   endgenerate

   assign at_top = (count == TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (inc && !at_top) begin
         count <= count + {{(W-1){1'b0}}, 1'b1};
      end
   end

   // R7: a full counter stays full
   a_r7_sat_hold : assert property (@(posedge clk) disable iff (rst)
      (count == TOP) |=> (count == TOP))
      else $error("counter left saturation");

   // R6: counter moves only on an increment request
   a_r6_no_spurious_step : assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(count))
      else $error("counter changed without increment");

endmodule

// File: rtl/ant_err_selector.sv
module ant_err_selector #(
   parameter int MAIN_OP_W = 12,
   parameter int REP_OP_W  = 6,
   parameter int CNT_W     = 16
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 in_valid,
   input  logic [2*MAIN_OP_W-1:0]               main_prod,
   input  logic [2*REP_OP_W-1:0]                rep_prod,
   input  logic                                 thr_we,
   input  logic [2*MAIN_OP_W-1:0]               thr_wdata,
   output logic                                 out_valid,
   output logic [2*MAIN_OP_W-1:0]               out_prod,
   output logic                                 out_fix,
   output logic [CNT_W-1:0]                     fix_count
);
   import ant_sel_pkg::*;

   localparam int PROD_W     = prod_width(MAIN_OP_W);
   localparam int REP_PROD_W = prod_width(REP_OP_W);

   generate
      if (REP_OP_W < 1 || REP_OP_W > MAIN_OP_W) begin : g_bad_rep
         $error("ant_err_selector: replica operand width out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ant_err_selector: counter width must be positive");
      end
   endgenerate

   logic [PROD_W-1:0] rep_aligned;
   logic [PROD_W-1:0] gap;
   logic [PROD_W-1:0] thr_q;
   pick_e             pick;
   logic              fix_event;

   ant_align #(.DST_W(PROD_W), .SRC_W(REP_PROD_W)) i_align (
      .src (rep_prod),
      .dst (rep_aligned)
   );

   ant_absdiff #(.W(PROD_W)) i_absdiff (
      .a   (main_prod),
      .b   (rep_aligned),
      .mag (gap)
   );

   // threshold holds its value through reset on purpose
   always_ff @(posedge clk) begin
      if (thr_we) begin
         thr_q <= thr_wdata;
      end
   end

   always_comb begin
      pick      = (gap > thr_q) ? PICK_REPLICA : PICK_MAIN;
      fix_event = in_valid && (pick == PICK_REPLICA);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_fix   <= 1'b0;
         out_prod  <= '0;
      end else begin
         out_valid <= in_valid;
         out_fix   <= fix_event;
         if (in_valid) begin
            out_prod <= (pick == PICK_REPLICA) ? rep_aligned : main_prod;
         end
      end
   end

   ant_sat_counter #(.W(CNT_W)) i_counter (
      .clk   (clk),
      .rst   (rst),
      .inc   (fix_event),
      .count (fix_count)
   );

   // R1: valid follows input valid by one cycle
   a_r1_valid_latency : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid)
      else $error("valid not forwarded");

   // R10: idle input gives idle, unflagged output and a held product
   a_r10_idle : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_fix && $stable(out_prod)))
      else $error("idle cycle produced output");

   // R4: accepted main product passes through unchanged
   a_r4_main_pass : assert property (@(posedge clk) disable iff (rst)
      (in_valid && pick == PICK_MAIN) |=> (out_prod == $past(main_prod) && !out_fix))
      else $error("main product not forwarded");

   // R5: rejected main product is replaced and flagged
   a_r5_replica_pass : assert property (@(posedge clk) disable iff (rst)
      (in_valid && pick == PICK_REPLICA) |=> (out_prod == $past(rep_aligned) && out_fix))
      else $error("replica product not forwarded");

   // R5: a flag only accompanies a valid sample
   a_r5_flag_valid : assert property (@(posedge clk) disable iff (rst)
      out_fix |-> out_valid)
      else $error("flag without valid");

   // R6: each replacement below saturation adds one
   a_r6_count_step : assert property (@(posedge clk) disable iff (rst)
      (fix_event && fix_count != {CNT_W{1'b1}}) |=>
         (fix_count == $past(fix_count) + {{(CNT_W-1){1'b0}}, 1'b1}))
      else $error("count did not step");

   // R8: threshold changes only on a write
   a_r8_thr_hold : assert property (@(posedge clk) disable iff (rst)
      !thr_we |=> $stable(thr_q))
      else $error("threshold changed without write");

   // R2: aligned replica has clear low bits
   a_r2_zero_fill : assert property (@(posedge clk) disable iff (rst)
      (rep_aligned[PROD_W-REP_PROD_W-1:0] == '0) || (PROD_W == REP_PROD_W))
      else $error("alignment low bits not zero");

endmodule

// File: tb/test_ant_err_selector.sv
module test_ant_err_selector;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   typedef struct packed {
      logic [23:0] thr;
      logic [23:0] mainp;
      logic [11:0] rep;
      logic [23:0] exp_prod;
      logic        exp_fix;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VEC [0:NVEC-1] = '{
      '{24'h001000, 24'h123456, 12'h123, 24'h123456, 1'b0},
      '{24'h001000, 24'h123456, 12'h124, 24'h123456, 1'b0},
      '{24'h001000, 24'h000000, 12'h800, 24'h800000, 1'b1},
      '{24'h001000, 24'hFFFFFF, 12'h000, 24'h000000, 1'b1},
      '{24'h001000, 24'h125000, 12'h124, 24'h125000, 1'b0},
      '{24'h001000, 24'h125001, 12'h124, 24'h124000, 1'b1},
      '{24'h001000, 24'h122FFF, 12'h124, 24'h124000, 1'b1},
      '{24'h001000, 24'h123000, 12'h124, 24'h123000, 1'b0},
      '{24'h000000, 24'h124000, 12'h124, 24'h124000, 1'b0},
      '{24'h000000, 24'h124001, 12'h124, 24'h124000, 1'b1},
      '{24'hFFFFFF, 24'hFFFFFF, 12'h000, 24'hFFFFFF, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [23:0] main_prod;
   logic [11:0] rep_prod;
   logic        thr_we;
   logic [23:0] thr_wdata;
   logic        out_valid;
   logic [23:0] out_prod;
   logic        out_fix;
   logic [15:0] fix_count;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ant_err_selector i_ant_err_selector (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .main_prod (main_prod),
      .rep_prod  (rep_prod),
      .thr_we    (thr_we),
      .thr_wdata (thr_wdata),
      .out_valid (out_valid),
      .out_prod  (out_prod),
      .out_fix   (out_fix),
      .fix_count (fix_count)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_thr(input logic [23:0] v);
      @(negedge clk);
      in_valid  = 1'b0;
      thr_we    = 1'b1;
      thr_wdata = v;
      @(negedge clk);
      thr_we    = 1'b0;
   endtask

   // drive one sample, sample the result one cycle later
   task automatic sample(input logic [23:0] m, input logic [11:0] r);
      in_valid  = 1'b1;
      main_prod = m;
      rep_prod  = r;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int exp_cnt;
      rst = 1'b1; in_valid = 1'b0; main_prod = '0; rep_prod = '0;
      thr_we = 1'b0; thr_wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R9: reset state
      chk(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
      chk(out_prod == 24'h0, "R9 prod", 32'(out_prod), 0);
      chk(out_fix == 1'b0, "R9 fix", 32'(out_fix), 0);
      chk(fix_count == 16'h0, "R9 count", 32'(fix_count), 0);

      // table walk: R1 R2 R3 R4 R5 R6
      exp_cnt = 0;
      for (int i = 0; i < NVEC; i++) begin
         load_thr(VEC[i].thr);
         sample(VEC[i].mainp, VEC[i].rep);
         if (VEC[i].exp_fix) exp_cnt++;
         chk(out_valid == 1'b1, "R1 valid latency", 32'(out_valid), 1);
         chk(out_prod == VEC[i].exp_prod, "R4/R5 selected product R2 R3",
             32'(out_prod), 32'(VEC[i].exp_prod));
         chk(out_fix == VEC[i].exp_fix, "R5 flag", 32'(out_fix), 32'(VEC[i].exp_fix));
         chk(fix_count == 16'(exp_cnt), "R6 count", 32'(fix_count), 32'(exp_cnt));
      end

      // R10: idle cycle with mismatching products
      load_thr(24'h000000);
      in_valid = 1'b0; main_prod = 24'hABCDEF; rep_prod = 12'h001;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 no valid", 32'(out_valid), 0);
      chk(out_fix == 1'b0, "R10 no flag", 32'(out_fix), 0);
      chk(fix_count == 16'(exp_cnt), "R10 count held", 32'(fix_count), 32'(exp_cnt));
      chk(out_prod == 24'hFFFFFF, "R10 product held", 32'(out_prod), 32'hFFFFFF);

      // R8: threshold survives reset
      load_thr(24'h000010);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(fix_count == 16'h0, "R9 count after reset", 32'(fix_count), 0);
      sample(24'h000010, 12'h000);
      chk(out_fix == 1'b0, "R8 equal to kept threshold", 32'(out_fix), 0);
      sample(24'h000011, 12'h000);
      chk(out_fix == 1'b1, "R8 above kept threshold", 32'(out_fix), 1);
      chk(fix_count == 16'h1, "R6 count after reset", 32'(fix_count), 1);

      // R7: saturation
      in_valid = 1'b1; main_prod = 24'h000011; rep_prod = 12'h000;
      repeat (65540) @(negedge clk);
      chk(fix_count == 16'hFFFF, "R7 saturated", 32'(fix_count), 32'hFFFF);
      chk(out_fix == 1'b1, "R7 flag still raised", 32'(out_fix), 1);
      @(negedge clk);
      chk(fix_count == 16'hFFFF, "R7 held at top", 32'(fix_count), 32'hFFFF);
      in_valid = 1'b0;
      @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule